// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block merges per-source interrupt flags, enables and priority bits into a single request to a CPU. The request carries the vector address the CPU should jump to. It holds the two global enable bits and clears them in hardware when the CPU takes a vector. It sets them again when the CPU signals a return. A small in-service state records which level is running, so that a high-priority routine which interrupted a low-priority one hands control back to the low level. On every vector entry, a one-deep shadow store captures three CPU registers. The store hands them back on a return that asks for the fast option.

There are two modes. In legacy mode (`prio_mode` = 0), the priority bits are ignored and every source is high priority. The upper global bit enables everything. The lower global bit acts as the enable for the sources marked as peripherals in `PERIPH_MASK`. In prioritized mode (`prio_mode` = 1), the upper global bit gates all requests and the lower global bit gates low-priority requests only. A high-priority request preempts a running low-priority routine. A low-priority request never preempts a high-priority routine.

The CPU sees `irq` and `vec_addr` as plain level outputs. It pulses `ack` for one cycle when it takes the vector, and `ret` for one cycle when it leaves a routine. Neither strobe uses a handshake.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, both global enables read 0, `irq` is 0, `vec_addr` is 0 and no routine is in service.
- R2: In legacy mode, `irq` is 1 with `vec_addr` = 0x000008 when the upper global enable is 1 and some source has both flag and enable set. For a source whose bit in `PERIPH_MASK` is 1, the lower global enable must also be 1. The priority bits have no effect.
- R3: In prioritized mode, a source with priority bit 1 requests the vector 0x000008 and needs only the upper global enable. A source with priority bit 0 requests the vector 0x000018 and needs both global enables.
- R4: When high and low requests are present together, `vec_addr` is 0x000008. `vec_addr` is 0 while `irq` is 0.
- R5: An `ack` while a high request is shown clears the upper global enable on the next cycle. An `ack` while only a low request is shown clears the lower global enable on the next cycle.
- R6: During a low-priority routine, an enabled high-priority source raises `irq` with vector 0x000008 even though the lower enable is 0. During a high-priority routine, no low-priority request is raised.
- R7: A `ret` sets the global enable of the level being left: the upper one from a high routine and the lower one from a low routine. A return from a high routine that had preempted a low one leaves the low routine in service, so the next `ret` sets the lower enable. When no routine is in service, `ret` has no effect, and `ack` takes precedence over `ret` in the same cycle.
- R8: `wake` is 1 whenever some source has flag and enable both set, whatever the global enables, the mode and the in-service state.
- R9: On every accepted `ack`, the shadow store captures `shadow_in`. `restore_stb` is 1 during a cycle with `ret` = 1, `ret_fast` = 1 and a routine in service, and 0 otherwise. `shadow_out` holds the value captured at the latest accepted `ack`.
- R10: A cycle with `ge_we` = 1 and neither `ack` nor `ret` loads `ge_wdata` into the enables: bit 1 into the upper enable and bit 0 into the lower enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_flag | input | NSRC | Per-source interrupt flags |
| src_en | input | NSRC | Per-source enables |
| src_prio | input | NSRC | Per-source priority (1 = high) |
| prio_mode | input | 1 | 1 = prioritized mode, 0 = legacy mode |
| ge_we | input | 1 | Software write of the global enables |
| ge_wdata | input | 2 | Bit 1 = upper enable, bit 0 = lower enable |
| ack | input | 1 | CPU takes the presented vector |
| ret | input | 1 | CPU returns from a routine |
| ret_fast | input | 1 | Return restores the shadow registers |
| shadow_in | input | 3*SHW | Three CPU registers to capture |
| irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | AW | Vector address of the request |
| wake | output | 1 | Wake-up request |
| ge_hi | output | 1 | Upper global enable |
| ge_lo | output | 1 | Lower global enable |
| restore_stb | output | 1 | Shadow values valid to restore |
| shadow_out | output | 3*SHW | Stored shadow values |

## Verification
Some properties are checked on every cycle. A taken high vector always clears the upper enable, and a taken low vector always clears the lower one. A high and a low request are never shown together. No low request appears during a high routine. `irq` never appears without `wake`, and the shadow store changes only on an accepted vector. The request logic is swept over every combination of flag, enable and priority, for both modes and all four enable settings. Only directed scenarios show that a high routine nested inside a low one hands back to the low level, and that the fast return delivers the registers captured at the latest entry.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    SVC_IDLE  = 2'd0,
    SVC_LO    = 2'd1,
    SVC_HI    = 2'd2,
    SVC_HI_LO = 2'd3
  } svc_state_t;
endpackage

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int NSRC = 4,
  parameter logic [NSRC-1:0] PERIPH_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_flag,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_prio,
  input  logic            prio_mode,
  input  logic            ge_hi,
  input  logic            ge_lo,
  input  logic            hi_busy,
  input  logic            any_busy,
  output logic            hi_req,
  output logic            lo_req,
  output logic            wake
);
  logic [NSRC-1:0] armed;
  logic [NSRC-1:0] legacy_ok;
  logic            hi_any, lo_any, leg_any;

  assign armed = src_flag & src_en;

  // peripheral sources additionally need the lower enable in legacy mode
  for (genvar i = 0; i < NSRC; i++) begin : g_leg
    if (PERIPH_MASK[i]) begin : g_per
      assign legacy_ok[i] = armed[i] & ge_lo;
    end else begin : g_core
      assign legacy_ok[i] = armed[i];
    end
  end

  assign leg_any = |legacy_ok;
  assign hi_any  = |(armed & src_prio);
  assign lo_any  = |(armed & ~src_prio);

  always_comb begin
    if (prio_mode) begin
      hi_req = ge_hi & ~hi_busy & hi_any;
      lo_req = ge_hi & ge_lo & ~any_busy & lo_any & ~hi_req;
    end else begin
      hi_req = ge_hi & ~hi_busy & leg_any;
      lo_req = 1'b0;
    end
  end

  assign wake = |armed;

  // R4
  one_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_req, lo_req}));
endmodule

// File: rtl/irq_level_fsm.sv
module irq_level_fsm
  import prio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hi_req,
  input  logic       lo_req,
  input  logic       ack,
  input  logic       ret,
  input  logic       ge_we,
  input  logic [1:0] ge_wdata,
  output logic       ge_hi,
  output logic       ge_lo,
  output logic       hi_busy,
  output logic       any_busy,
  output logic       take
);
  svc_state_t state_q;
  logic       ret_ok;

  assign take     = ack & (hi_req | lo_req);
  assign ret_ok   = ret & ~take & (state_q != SVC_IDLE);
  assign hi_busy  = (state_q == SVC_HI) || (state_q == SVC_HI_LO);
  assign any_busy = (state_q != SVC_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SVC_IDLE;
      ge_hi   <= 1'b0;
      ge_lo   <= 1'b0;
    end else if (take) begin
      if (hi_req) begin
        ge_hi   <= 1'b0;
        state_q <= (state_q == SVC_LO) ? SVC_HI_LO : SVC_HI;
      end else begin
        ge_lo   <= 1'b0;
        state_q <= SVC_LO;
      end
    end else if (ret_ok) begin
      case (state_q)
        SVC_HI:    begin ge_hi <= 1'b1; state_q <= SVC_IDLE; end
        SVC_HI_LO: begin ge_hi <= 1'b1; state_q <= SVC_LO;   end
        default:   begin ge_lo <= 1'b1; state_q <= SVC_IDLE; end
      endcase
    end else if (ge_we && !ack && !ret) begin
      ge_hi <= ge_wdata[1];
      ge_lo <= ge_wdata[0];
    end
  end

  // R5
  hi_entry_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && hi_req) |=> !ge_hi);
  // R5
  lo_entry_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && lo_req && !hi_req) |=> !ge_lo);
  // R6
  no_lo_in_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_busy |-> !lo_req);
endmodule

// File: rtl/irq_shadow.sv
module irq_shadow #(
  parameter int SHW   = 8,
  parameter int NREGS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap,
  input  logic [NREGS*SHW-1:0] d,
  output logic [NREGS*SHW-1:0] q
);
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[r*SHW +: SHW] <= '0;
      else if (cap) q[r*SHW +: SHW] <= d[r*SHW +: SHW];
    end
  end

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(q));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 4,
  parameter logic [NSRC-1:0] PERIPH_MASK = 4'b1100,
  parameter int AW  = 24,
  parameter int SHW = 8,
  parameter logic [AW-1:0] HI_VEC = 24'h000008,
  parameter logic [AW-1:0] LO_VEC = 24'h000018
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_flag,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_prio,
  input  logic             prio_mode,
  input  logic             ge_we,
  input  logic [1:0]       ge_wdata,
  input  logic             ack,
  input  logic             ret,
  input  logic             ret_fast,
  input  logic [3*SHW-1:0] shadow_in,
  output logic             irq,
  output logic [AW-1:0]    vec_addr,
  output logic             wake,
  output logic             ge_hi,
  output logic             ge_lo,
  output logic             restore_stb,
  output logic [3*SHW-1:0] shadow_out
);
  localparam int NREGS = 3;

  logic hi_req, lo_req, hi_busy, any_busy, take;

  irq_req_gen #(.NSRC(NSRC), .PERIPH_MASK(PERIPH_MASK)) u_req (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .src_prio(src_prio), .prio_mode(prio_mode), .ge_hi(ge_hi), .ge_lo(ge_lo),
    .hi_busy(hi_busy), .any_busy(any_busy), .hi_req(hi_req), .lo_req(lo_req),
    .wake(wake));

  irq_level_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hi_req(hi_req), .lo_req(lo_req), .ack(ack),
    .ret(ret), .ge_we(ge_we), .ge_wdata(ge_wdata), .ge_hi(ge_hi), .ge_lo(ge_lo),
    .hi_busy(hi_busy), .any_busy(any_busy), .take(take));

  irq_shadow #(.SHW(SHW), .NREGS(NREGS)) u_shd (
    .clk(clk), .rst_n(rst_n), .cap(take), .d(shadow_in), .q(shadow_out));

  assign irq         = hi_req | lo_req;
  assign vec_addr    = hi_req ? HI_VEC : (lo_req ? LO_VEC : '0);
  assign restore_stb = ret & ret_fast & any_busy & ~take;

  // R8
  irq_needs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;
  localparam logic [NSRC-1:0] PM = 4'b1100;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_flag = 0, src_en = 0, src_prio = 0;
  logic prio_mode = 0, ge_we = 0, ack = 0, ret = 0, ret_fast = 0;
  logic [1:0] ge_wdata = 0;
  logic [23:0] shadow_in = 0;
  logic irq, wake, ge_hi, ge_lo, restore_stb;
  logic [23:0] vec_addr, shadow_out;
  int checks = 0, errors = 0, cyc = 0;

  prio_irq_ctrl u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr_ge(input logic [1:0] v);
    ge_wdata = v; ge_we = 1; tick(); ge_we = 0;
  endtask

  task automatic pulse_ack(input logic [23:0] regs);
    shadow_in = regs; ack = 1; tick(); ack = 0;
  endtask

  task automatic pulse_ret(input logic fast);
    ret = 1; ret_fast = fast; tick(); ret = 0; ret_fast = 0;
  endtask

  initial begin
    wait (cyc > 60000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic eh, el, m_any;
    logic [NSRC-1:0] m;
    logic [23:0] ev;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 ge_hi", ge_hi, 0); chk("R1 ge_lo", ge_lo, 0);
    chk("R1 irq", irq, 0); chk("R1 vec", vec_addr, 0);
    rst_n = 1; tick();
    // R7 ret while idle has no effect
    pulse_ret(1'b1);
    chk("R7 idle ret ge", {ge_hi, ge_lo}, 0);
    // R10 software write
    wr_ge(2'b10); chk("R10 write", {ge_hi, ge_lo}, 2'b10);

    // exhaustive sweep of request logic (R2 R3 R4 R8)
    for (int md = 0; md < 2; md++) begin
      prio_mode = md[0];
      for (int g = 0; g < 4; g++) begin
        wr_ge(g[1:0]);
        for (int c = 0; c < 4096; c++) begin
          src_flag = c[3:0]; src_en = c[7:4]; src_prio = c[11:8];
          #1;
          m = src_flag & src_en; m_any = |m;
          if (md == 0) begin
            eh = g[1] && |(m & (~PM | (g[0] ? 4'hF : 4'h0)));
            el = 0;
          end else begin
            eh = g[1] && |(m & src_prio);
            el = g[1] && g[0] && |(m & ~src_prio) && !eh;
          end
          ev = eh ? 24'h8 : (el ? 24'h18 : 24'h0);
          chk(md == 0 ? "R2 irq" : "R3 irq", irq, eh | el);
          chk("R4 vec", vec_addr, ev);
          chk("R8 wake", wake, m_any);
        end
      end
    end
    src_flag = 0; src_en = 0; src_prio = 0;

    // R5/R6/R7/R9 nested scenario, prioritized mode
    prio_mode = 1; wr_ge(2'b11);
    src_en = 4'b0011; src_prio = 4'b0010; src_flag = 4'b0001;
    #1; chk("R3 lo vec", vec_addr, 24'h18);
    pulse_ack(24'hA1B2C3);
    chk("R5 lo clears ge_lo", {ge_hi, ge_lo}, 2'b10);
    chk("R5 no irq in lo", irq, 0);
    chk("R9 capture1", shadow_out, 24'hA1B2C3);
    src_flag = 4'b0011; #1;
    chk("R6 preempt irq", irq, 1); chk("R6 preempt vec", vec_addr, 24'h8);
    pulse_ack(24'h445566);
    chk("R5 hi clears ge_hi", {ge_hi, ge_lo}, 2'b00);
    chk("R9 capture2", shadow_out, 24'h445566);
    src_flag = 4'b0001;
    pulse_ret(1'b0);
    chk("R7 hi ret sets ge_hi", {ge_hi, ge_lo}, 2'b10);
    chk("R7 back in lo no irq", irq, 0);
    ret = 1; ret_fast = 1; #1;
    chk("R9 restore stb", restore_stb, 1);
    chk("R9 restore data", shadow_out, 24'h445566);
    tick(); ret = 0; ret_fast = 0;
    chk("R7 lo ret sets ge_lo", {ge_hi, ge_lo}, 2'b11);
    chk("R3 lo pending again", vec_addr, 24'h18);
    ret = 1; ret_fast = 1; #1;
    chk("R9 no stb idle", restore_stb, 0);
    tick(); ret = 0; ret_fast = 0;

    // R6 low cannot preempt high
    src_flag = 4'b0010; #1;
    pulse_ack(24'h0);
    src_flag = 4'b0001; #1;
    chk("R6 lo blocked in hi", irq, 0);
    chk("R8 wake in hi", wake, 1);
    wr_ge(2'b11); #1;
    chk("R6 lo blocked even ge set", irq, 0);
    pulse_ret(1'b0);
    chk("R7 after hi lo served", vec_addr, 24'h18);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule